// File: doc/BRIEF.md
# Configuration Access Router

This block takes single configuration accesses from a memory-mapped programmed-I/O port and steers each one to one of up to 256 function slots (32 devices with 8 functions each). It removes the window base from the incoming address, splits the resulting offset into a slot index and a register offset, and checks the access size. It also samples a presence vector to see whether the target slot is populated.

A legal access to a populated slot goes out on a shared downstream port. That port has a valid/ready handshake and a one-hot slot select. Every other access is answered locally: reads of empty slots return all-ones, and everything else that cannot be served gets an error response. Only one access is in flight at a time. The response is presented after a fixed, parameter-set number of cycles.

The controller has three states. IDLE accepts a request. FWD drives the downstream port until it is taken. HOLD counts the response latency and presents the response in its last cycle. The transitions are:

- IDLE to FWD (accept-forward): taken when a legal request hits a populated slot.
- IDLE to HOLD (accept-local): taken for any other accepted request.
- FWD to HOLD (handshake): taken when the downstream port asserts ready.
- HOLD to IDLE (respond): taken at the end of the response cycle.

Top module: `cfg_router`

## Requirements
- R1: Out of reset, `req_ready` is 1 and `dn_valid` and `rsp_valid` are 0.
- R2: The offset is `req_addr - (BASE_ADDR & IMPL_MASK)`. The device is offset[15:11], the function is offset[10:8] and the register is offset[7:0]. A forwarded access sets `dn_sel` bit device*8+function and drives the register on `dn_reg`.
- R3: The byte count on `req_size` is legal only for the values 1, 2 and 4. Any other value gives an error response with zero data, for reads and writes alike, and nothing is forwarded.
- R4: A legal-size read of an absent slot is not forwarded. It completes with no error and returns 0xFF, 0xFFFF or 0xFFFFFFFF for sizes 1, 2 and 4.
- R5: A legal-size read of a present slot is forwarded with `dn_write`=0, the register offset and the size. Its response data is the low size bytes of `dn_rdata`, taken at the handshake, with the upper bytes zero and no error.
- R6: A write to an absent slot is not forwarded and gets an error response.
- R7: A legal-size write to a present slot is forwarded with `dn_write`=1, the register, the size and the data. It completes with no error and zero response data.
- R8: While `dn_valid` is high, `dn_sel` is one-hot and all downstream fields stay stable until `dn_ready`. When `dn_valid` is low, `dn_sel` is zero.
- R9: `rsp_valid` is high for exactly one cycle. That cycle is the LATENCY-th cycle after the acceptance edge for a locally answered access, or after the handshake edge for a forwarded one.
- R10: `req_ready` is low from the edge that accepts a request through the response cycle, and is high again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Router can accept a request |
| req_addr | input | ADDR_W | Physical request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| present | input | 256 | Populated slots, index device*8+function |
| dn_valid | output | 1 | Downstream access valid |
| dn_ready | input | 1 | Downstream access taken |
| dn_sel | output | 256 | One-hot slot select |
| dn_write | output | 1 | Downstream direction |
| dn_reg | output | 8 | Register offset |
| dn_size | output | 3 | Access size in bytes |
| dn_wdata | output | 32 | Write data |
| dn_rdata | input | 32 | Read data, valid with dn_ready |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Response is an error |
| rsp_rdata | output | 32 | Response data, right-aligned |

## Verification
The bench sends reads to present slots with 4, 1 and 2 byte sizes and with downstream stalls of zero to two cycles. These show that the data is masked correctly per size and that the latency is counted from the handshake rather than from acceptance. Reads of an absent slot at all three sizes separate the synthesized all-ones path from the forwarded one. Writes to present and absent slots, and illegal sizes on both reads and writes, show which errors are raised and that nothing reaches the downstream port. Slots at index 0, 26 and 255 exercise the field split at both ends of the select vector.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FWD  = 2'd1,
        ST_HOLD = 2'd2
    } rt_state_e;

    function automatic logic size_legal(input logic [2:0] nbytes);
        return (nbytes == 3'd1) || (nbytes == 3'd2) || (nbytes == 3'd4);
    endfunction

    function automatic logic [31:0] size_mask(input logic [2:0] nbytes);
        logic [31:0] m;
        unique case (nbytes)
            3'd1:    m = 32'h0000_00FF;
            3'd2:    m = 32'h0000_FFFF;
            3'd4:    m = 32'hFFFF_FFFF;
            default: m = 32'h0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
    parameter logic [ADDR_W-1:0] IMPL_MASK = '1,
    parameter int IDX_W = 8,
    parameter int REG_BITS = 8
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [IDX_W-1:0]    slot_idx,
    output logic [REG_BITS-1:0] reg_off
);
    localparam int LOW_W = IDX_W + REG_BITS;
    localparam logic [ADDR_W-1:0] EFF_BASE = BASE_ADDR & IMPL_MASK;

    logic [ADDR_W-1:0] offset;
    logic unused_hi;

    assign offset    = addr - EFF_BASE;
    assign slot_idx  = offset[LOW_W-1:REG_BITS];
    assign reg_off   = offset[REG_BITS-1:0];
    assign unused_hi = ^offset[ADDR_W-1:LOW_W];
endmodule

// File: rtl/cfg_slot_select.sv
module cfg_slot_select #(
    parameter int IDX_W = 8,
    localparam int SLOTS = 1 << IDX_W
) (
    input  logic             en,
    input  logic [IDX_W-1:0] idx,
    output logic [SLOTS-1:0] sel
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        assign sel[i] = en && (idx == IDX_W'(i));
    end
endmodule

// File: rtl/cfg_lat_timer.sv
module cfg_lat_timer #(
    parameter int LATENCY = 1,
    localparam int CNT_W = $clog2(LATENCY + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= CNT_W'(LATENCY);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expire = (cnt == CNT_W'(1));

    assert_expire_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        expire && !start |=> !expire);
endmodule

// File: rtl/cfg_router.sv
module cfg_router #(
    parameter int ADDR_W = 32,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 32'hF100_0000,
    parameter logic [ADDR_W-1:0] IMPL_MASK = 32'h00FF_FFFF,
    parameter int DEV_BITS = 5,
    parameter int FN_BITS = 3,
    parameter int REG_BITS = 8,
    parameter int LATENCY = 1,
    localparam int IDX_W = DEV_BITS + FN_BITS,
    localparam int SLOTS = 1 << IDX_W,
    localparam int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [2:0]        req_size,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [SLOTS-1:0]  present,
    output logic              dn_valid,
    input  logic              dn_ready,
    output logic [SLOTS-1:0]  dn_sel,
    output logic              dn_write,
    output logic [REG_BITS-1:0] dn_reg,
    output logic [2:0]        dn_size,
    output logic [DATA_W-1:0] dn_wdata,
    input  logic [DATA_W-1:0] dn_rdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata
);
    import cfg_router_pkg::*;

    rt_state_e state, state_n;

    logic [IDX_W-1:0]    in_idx, r_idx;
    logic [REG_BITS-1:0] in_reg, r_reg;
    logic [2:0]          r_size;
    logic                r_write;
    logic [DATA_W-1:0]   r_wdata, r_data;
    logic                r_err;
    logic                accept, legal, hit, go_fwd, handshake, tmr_start, expire;

    cfg_addr_decode #(
        .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .IMPL_MASK(IMPL_MASK),
        .IDX_W(IDX_W), .REG_BITS(REG_BITS)
    ) u_dec (
        .addr(req_addr), .slot_idx(in_idx), .reg_off(in_reg)
    );

    assign accept    = req_valid && (state == ST_IDLE);
    assign legal     = size_legal(req_size);
    assign hit       = present[in_idx];
    assign go_fwd    = legal && hit;
    assign handshake = (state == ST_FWD) && dn_ready;
    assign tmr_start = (accept && !go_fwd) || handshake;

    cfg_lat_timer #(.LATENCY(LATENCY)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(tmr_start), .expire(expire)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE: if (accept) state_n = go_fwd ? ST_FWD : ST_HOLD;
            ST_FWD:  if (dn_ready) state_n = ST_HOLD;
            ST_HOLD: if (expire) state_n = ST_IDLE;
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // captured request and result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_idx   <= '0;
            r_reg   <= '0;
            r_size  <= '0;
            r_write <= 1'b0;
            r_wdata <= '0;
            r_data  <= '0;
            r_err   <= 1'b0;
        end else if (accept) begin
            r_idx   <= in_idx;
            r_reg   <= in_reg;
            r_size  <= req_size;
            r_write <= req_write;
            r_wdata <= req_wdata;
            r_err   <= !legal || (req_write && !hit);
            r_data  <= (!legal || req_write) ? '0 : size_mask(req_size);
        end else if (handshake) begin
            r_err  <= 1'b0;
            r_data <= r_write ? '0 : (dn_rdata & size_mask(r_size));
        end
    end

    cfg_slot_select #(.IDX_W(IDX_W)) u_sel (
        .en(state == ST_FWD), .idx(r_idx), .sel(dn_sel)
    );

    // outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        dn_valid  = (state == ST_FWD);
        dn_write  = r_write;
        dn_reg    = r_reg;
        dn_size   = r_size;
        dn_wdata  = r_wdata;
        rsp_valid = (state == ST_HOLD) && expire;
        rsp_err   = rsp_valid && r_err;
        rsp_rdata = rsp_valid ? r_data : '0;
    end

    assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_sel_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> $onehot(dn_sel));

    assert_sel_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !dn_valid |-> (dn_sel == '0));

    assert_dn_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_valid && !dn_ready) |=> dn_valid && $stable(dn_sel) && $stable(dn_reg)
            && $stable(dn_size) && $stable(dn_write) && $stable(dn_wdata));

    assert_dn_size_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dn_valid |-> size_legal(dn_size));

    assert_rsp_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid && req_ready);

    assert_err_zero_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == '0));
endmodule

// File: tb/cfg_router_test.sv
`timescale 1ns/1ps
module cfg_router_test;
    localparam int LAT = 3;
    localparam logic [31:0] BASE = 32'hF100_0000;
    localparam logic [31:0] MASK = 32'h00FF_FFFF;

    logic clk = 0, rst_n = 0;
    logic req_valid = 0, req_write = 0, dn_ready = 0;
    logic [31:0] req_addr = 0, req_wdata = 0, dn_rdata = 0;
    logic [2:0] req_size = 0;
    logic [255:0] present = 0;
    logic req_ready, dn_valid, dn_write, rsp_valid, rsp_err;
    logic [255:0] dn_sel;
    logic [7:0] dn_reg;
    logic [2:0] dn_size;
    logic [31:0] dn_wdata, rsp_rdata;

    int errors = 0, checks = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cfg_router #(.BASE_ADDR(BASE), .IMPL_MASK(MASK), .LATENCY(LAT)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
        .req_wdata(req_wdata), .present(present), .dn_valid(dn_valid),
        .dn_ready(dn_ready), .dn_sel(dn_sel), .dn_write(dn_write), .dn_reg(dn_reg),
        .dn_size(dn_size), .dn_wdata(dn_wdata), .dn_rdata(dn_rdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] width_ones(input logic [2:0] sz);
        if (sz == 1) return 32'hFF;
        if (sz == 2) return 32'hFFFF;
        if (sz == 4) return 32'hFFFF_FFFF;
        return 32'h0;
    endfunction

    task automatic access(input int dev, input int fn, input int rg, input bit wr,
                          input logic [2:0] sz, input logic [31:0] wd,
                          input int stall, input logic [31:0] dd, input string tag);
        int idx = dev * 8 + fn;
        bit legal = (sz == 1) || (sz == 2) || (sz == 4);
        bit pres = present[idx];
        bit fwd = legal && pres;
        bit exp_err = !legal || (wr && !pres);
        logic [31:0] exp_data;
        if (exp_err || (wr && pres)) exp_data = 0;
        else if (!pres) exp_data = width_ones(sz);
        else exp_data = dd & width_ones(sz);

        @(negedge clk);
        req_valid = 1; req_write = wr; req_size = sz; req_wdata = wd;
        req_addr = (BASE & MASK) + 32'(dev * 2048 + fn * 256 + rg);
        chk(req_ready == 1, {"R10 ready before ", tag}, 32'(req_ready), 1);
        @(posedge clk); #1 req_valid = 0;

        if (fwd) begin
            for (int k = 0; k <= stall; k++) begin
                @(negedge clk);
                chk(dn_valid == 1, {"R8 dn_valid ", tag}, 32'(dn_valid), 1);
                chk(dn_sel[idx] == 1 && $countones(dn_sel) == 1, {"R2 dn_sel ", tag},
                    32'($countones(dn_sel)), 1);
                chk(dn_reg == 8'(rg), {"R2 dn_reg ", tag}, 32'(dn_reg), 32'(rg));
                chk(dn_size == sz && dn_write == wr, {"R5 R7 dn fields ", tag},
                    {28'(dn_size), 3'b0, dn_write}, {28'(sz), 3'b0, wr});
                if (wr) chk(dn_wdata == wd, {"R7 dn_wdata ", tag}, dn_wdata, wd);
                chk(req_ready == 0 && rsp_valid == 0, {"R10 busy in fwd ", tag},
                    {30'b0, req_ready, rsp_valid}, 0);
                if (k == stall) begin dn_ready = 1; dn_rdata = dd; end
                @(posedge clk);
            end
        end

        for (int c = 1; c <= LAT; c++) begin
            @(negedge clk);
            dn_ready = 0; dn_rdata = 32'h0BAD_0BAD;
            chk(dn_valid == 0, {"R3 R4 R6 no forward ", tag}, 32'(dn_valid), 0);
            chk(req_ready == 0, {"R10 busy in hold ", tag}, 32'(req_ready), 0);
            chk(rsp_valid == (c == LAT), {"R9 rsp timing ", tag}, 32'(rsp_valid), 32'(c == LAT));
            if (c == LAT) begin
                chk(rsp_err == exp_err, {"R3 R4 R5 R6 R7 rsp_err ", tag}, 32'(rsp_err), 32'(exp_err));
                chk(rsp_rdata == exp_data, {"R4 R5 rsp_rdata ", tag}, rsp_rdata, exp_data);
            end
            @(posedge clk);
        end
        @(negedge clk);
        chk(req_ready == 1 && rsp_valid == 0, {"R9 R10 after rsp ", tag},
            {30'b0, req_ready, rsp_valid}, 32'h2);
    endtask

    initial begin
        present[3*8+2] = 1;
        present[255] = 1;
        present[0] = 1;
        #12 rst_n = 1;
        @(negedge clk);
        chk(req_ready == 1 && dn_valid == 0 && rsp_valid == 0, "R1 reset state",
            {29'b0, req_ready, dn_valid, rsp_valid}, 32'h4);

        access(3, 2, 8'h10, 0, 4, 0, 0, 32'hDEAD_BEEF, "R5 read4 present");
        access(31, 7, 8'h03, 0, 1, 0, 2, 32'h1234_5678, "R5 read1 stall2");
        access(0, 0, 8'hFE, 0, 2, 0, 1, 32'h1234_5678, "R5 read2 slot0");
        access(5, 1, 8'h04, 0, 1, 0, 0, 0, "R4 absent read1");
        access(5, 1, 8'h04, 0, 2, 0, 0, 0, "R4 absent read2");
        access(5, 1, 8'h04, 0, 4, 0, 0, 0, "R4 absent read4");
        access(3, 2, 8'h20, 1, 4, 32'hCAFE_F00D, 1, 0, "R7 write4 present");
        access(31, 7, 8'h41, 1, 1, 32'h0000_00A5, 0, 0, "R7 write1 present");
        access(5, 1, 8'h08, 1, 4, 32'h1111_2222, 0, 0, "R6 absent write");
        access(3, 2, 8'h00, 0, 3, 0, 0, 32'hFFFF_FFFF, "R3 read size3");
        access(0, 0, 8'h00, 1, 0, 32'h5555_5555, 0, 0, "R3 write size0");
        access(5, 1, 8'h00, 0, 7, 0, 0, 0, "R3 absent read size7");
        done = 1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 20000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=<20000", cyc);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule